// File: doc/BRIEF.md
# Four-Bank Register File with Source Crossbar

This block stores 127 general registers of 64 bits across four storage banks. Each bank has two read ports and one write port. A register's bank is given by its number modulo four, and its row inside that bank by its number divided by four. Register 0 has no storage and always reads as zero.

Function units read operands through a source-side crossbar. Any read requester can fetch from any bank. A small arbiter shares each bank's two read slots among the requesters, and returns a same-cycle stall to any request that loses. Results do not pass through a crossbar. Each bank's single write port belongs to one function unit, which supplies a bank row, a byte mask and the data. Read data appears one cycle after the request is granted. A read of a row that is being written in the same cycle returns the value held before that write.

Top module: `banked_regfile`

## Requirements
- R1: Register r lives in bank r mod 4, row r div 4. A write on write port b to row w changes register 4*w+b, and a later read of that register number returns it.
- R2: Write-mask bit i of a write port updates only data bits 8*i+7 down to 8*i. Bytes whose mask bit is 0 keep their previous value.
- R3: A read request that is valid and not stalled at a rising edge produces rd_rvalid high and the register value on rd_data during the following cycle. In any other case rd_rvalid is low in that following cycle.
- R4: A read and a write of the same register at the same edge return the value held before the write. The next read returns the new value.
- R5: A read of register 0 returns zero, is never stalled and uses no bank read slot. A write to bank 0 row 0 has no effect on anything that can be read.
- R6: Requesters that target different banks in the same cycle are all served in that cycle, whichever bank each port selects.
- R7: When more than two non-zero requests target one bank in a cycle, the two lowest-numbered requesters are granted. Every other requester to that bank sees rd_stall high in the same cycle and gets no rd_rvalid in the next cycle.
- R8: After reset every register reads as zero and rd_rvalid is low.
- R9: rd_stall is high only for a requester whose rd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 4 | Per-bank write strobe |
| wr_row | input | 4x5 | Per-bank destination row |
| wr_be | input | 4x8 | Per-bank byte write mask, bit i covers byte i |
| wr_data | input | 4x64 | Per-bank write data |
| rd_valid | input | 4 | Read request per requester |
| rd_reg | input | 4x7 | Register number per requester |
| rd_stall | output | 4 | Request lost bank arbitration this cycle |
| rd_rvalid | output | 4 | Read data valid, one cycle after the grant |
| rd_data | output | 4x64 | Read data per requester |

## Verification
The bench drives all four requesters into one bank. A design that let the wrong requesters win, or gave out a third slot, would show the wrong stall pattern or corrupt data on a granted port. It issues a read and a write to one register at the same edge. A store that forwarded the new value there would fail that check. It mixes register-0 reads with same-bank reads, which catches a design that charged register 0 a bank slot and so stalled a later requester. Partial byte masks go to every bank. A bank that wrote whole words, or whose mapping of register number to bank and row was wrong, would return the wrong word.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int DATA_W   = 64;
    localparam int BANKS    = 4;
    localparam int ROWS     = 32;
    localparam int RD_PORTS = 4;
    localparam int BANK_RD  = 2;

    localparam int BYTES  = DATA_W / 8;
    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int REG_W  = BANK_W + ROW_W;
    localparam int SLOT_W = (BANK_RD > 1) ? $clog2(BANK_RD) : 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [SLOT_W-1:0] slot_t;

    // Where a granted read will pick up its data in the next cycle.
    typedef struct packed {
        logic  live;
        logic  zero;
        bank_t bank;
        slot_t slot;
    } route_t;
endpackage

// File: rtl/brf_bank.sv
module brf_bank
    import brf_pkg::*;
#(
    parameter bit ZERO_ROW = 1'b0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [BANK_RD-1:0]               rd_en,
    input  logic [BANK_RD-1:0][ROW_W-1:0]    rd_row,
    input  logic                             wr_en,
    input  logic [ROW_W-1:0]                 wr_row,
    input  logic [BYTES-1:0]                 wr_be,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [BANK_RD-1:0][DATA_W-1:0]   rd_dout
);
    typedef struct packed {
        logic [ROWS-1:0][DATA_W-1:0]    mem;
        logic [BANK_RD-1:0][DATA_W-1:0] dout;
    } bank_state_t;

    bank_state_t st_d, st_q;
    logic        wr_ok;

    assign wr_ok = wr_en && !(ZERO_ROW && (wr_row == '0));

    always_comb begin
        st_d = st_q;
        // Reads look at the stored value before this edge's write.
        for (int s = 0; s < BANK_RD; s++) begin
            if (rd_en[s]) begin
                st_d.dout[s] = st_q.mem[rd_row[s]];
            end
        end
        if (wr_ok) begin
            for (int by = 0; by < BYTES; by++) begin
                if (wr_be[by]) begin
                    st_d.mem[wr_row][by*8 +: 8] = wr_data[by*8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_dout = st_q.dout;
endmodule

// File: rtl/brf_rd_arb.sv
module brf_rd_arb
    import brf_pkg::*;
(
    input  logic [RD_PORTS-1:0]                     rd_valid,
    input  logic [RD_PORTS-1:0][REG_W-1:0]          rd_reg,
    output logic [RD_PORTS-1:0]                     rd_stall,
    output route_t [RD_PORTS-1:0]                   route,
    output logic [BANKS-1:0][BANK_RD-1:0]           bank_en,
    output logic [BANKS-1:0][BANK_RD-1:0][ROW_W-1:0] bank_row
);
    int used [BANKS];

    always_comb begin
        rd_stall = '0;
        route    = '0;
        bank_en  = '0;
        bank_row = '0;
        for (int b = 0; b < BANKS; b++) begin
            used[b] = 0;
        end
        // Fixed priority: lower requester index claims a slot first.
        for (int p = 0; p < RD_PORTS; p++) begin
            if (rd_valid[p]) begin
                if (rd_reg[p] == '0) begin
                    route[p].live = 1'b1;
                    route[p].zero = 1'b1;
                end else if (used[int'(rd_reg[p][BANK_W-1:0])] < BANK_RD) begin
                    route[p].live = 1'b1;
                    route[p].bank = rd_reg[p][BANK_W-1:0];
                    route[p].slot = slot_t'(used[int'(rd_reg[p][BANK_W-1:0])]);
                    bank_en[rd_reg[p][BANK_W-1:0]][used[int'(rd_reg[p][BANK_W-1:0])]] = 1'b1;
                    bank_row[rd_reg[p][BANK_W-1:0]][used[int'(rd_reg[p][BANK_W-1:0])]] =
                        rd_reg[p][REG_W-1:BANK_W];
                    used[int'(rd_reg[p][BANK_W-1:0])] = used[int'(rd_reg[p][BANK_W-1:0])] + 1;
                end else begin
                    rd_stall[p] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/brf_rd_xbar.sv
module brf_rd_xbar
    import brf_pkg::*;
(
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  route_t [RD_PORTS-1:0]                     route_in,
    input  logic [BANKS-1:0][BANK_RD-1:0][DATA_W-1:0] bank_dout,
    output logic [RD_PORTS-1:0]                       rd_rvalid,
    output logic [RD_PORTS-1:0][DATA_W-1:0]           rd_data
);
    route_t [RD_PORTS-1:0] route_d, route_q;

    always_comb begin
        route_d = route_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else begin
            route_q <= route_d;
        end
    end

    always_comb begin
        for (int p = 0; p < RD_PORTS; p++) begin
            rd_rvalid[p] = route_q[p].live;
            if (route_q[p].live && !route_q[p].zero) begin
                rd_data[p] = bank_dout[route_q[p].bank][route_q[p].slot];
            end else begin
                rd_data[p] = '0;
            end
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [BANKS-1:0]                  wr_en,
    input  logic [BANKS-1:0][ROW_W-1:0]       wr_row,
    input  logic [BANKS-1:0][BYTES-1:0]       wr_be,
    input  logic [BANKS-1:0][DATA_W-1:0]      wr_data,
    input  logic [RD_PORTS-1:0]               rd_valid,
    input  logic [RD_PORTS-1:0][REG_W-1:0]    rd_reg,
    output logic [RD_PORTS-1:0]               rd_stall,
    output logic [RD_PORTS-1:0]               rd_rvalid,
    output logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data
);
    route_t [RD_PORTS-1:0]                     route;
    logic [BANKS-1:0][BANK_RD-1:0]             bank_en;
    logic [BANKS-1:0][BANK_RD-1:0][ROW_W-1:0]  bank_row;
    logic [BANKS-1:0][BANK_RD-1:0][DATA_W-1:0] bank_dout;

    brf_rd_arb u_arb (
        .rd_valid (rd_valid),
        .rd_reg   (rd_reg),
        .rd_stall (rd_stall),
        .route    (route),
        .bank_en  (bank_en),
        .bank_row (bank_row)
    );

    // Each write port is wired to its own bank; only reads cross banks.
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        brf_bank #(
            .ZERO_ROW (b == 0)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_en   (bank_en[b]),
            .rd_row  (bank_row[b]),
            .wr_en   (wr_en[b]),
            .wr_row  (wr_row[b]),
            .wr_be   (wr_be[b]),
            .wr_data (wr_data[b]),
            .rd_dout (bank_dout[b])
        );
    end

    brf_rd_xbar u_xbar (
        .clk       (clk),
        .rst_n     (rst_n),
        .route_in  (route),
        .bank_dout (bank_dout),
        .rd_rvalid (rd_rvalid),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/brf_checker.sv
module brf_checker
    import brf_pkg::*;
(
    input logic                              clk,
    input logic                              rst_n,
    input logic [BANKS-1:0]                  wr_en,
    input logic [BANKS-1:0][ROW_W-1:0]       wr_row,
    input logic [BANKS-1:0][BYTES-1:0]       wr_be,
    input logic [BANKS-1:0][DATA_W-1:0]      wr_data,
    input logic [RD_PORTS-1:0]               rd_valid,
    input logic [RD_PORTS-1:0][REG_W-1:0]    rd_reg,
    input logic [RD_PORTS-1:0]               rd_stall,
    input logic [RD_PORTS-1:0]               rd_rvalid,
    input logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data
);
    logic [RD_PORTS-1:0] req_nz;
    int                  ahead [RD_PORTS];
    logic [RD_PORTS-1:0] granted;

    always_comb begin
        for (int p = 0; p < RD_PORTS; p++) begin
            req_nz[p]  = rd_valid[p] && (rd_reg[p] != '0);
            granted[p] = req_nz[p] && !rd_stall[p];
        end
        for (int p = 0; p < RD_PORTS; p++) begin
            ahead[p] = 0;
            for (int q = 0; q < p; q++) begin
                if (req_nz[q] && (rd_reg[q][BANK_W-1:0] == rd_reg[p][BANK_W-1:0])) begin
                    ahead[p] = ahead[p] + 1;
                end
            end
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_port
        AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stall[p] |-> (rd_valid[p] && rd_reg[p] != '0)); // R9
        AST_LOWER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stall[p] == (req_nz[p] && ahead[p] >= BANK_RD)); // R7
        AST_RVALID_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[p] && !rd_stall[p]) |=> rd_rvalid[p]); // R3
        AST_NO_RVALID_UNGRANTED: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_valid[p] && !rd_stall[p]) |=> !rd_rvalid[p]); // R3
        AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid[p] && rd_reg[p] == '0) |=> (rd_rvalid[p] && rd_data[p] == '0)); // R5
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank_lim
        logic [RD_PORTS-1:0] hit;
        always_comb begin
            for (int p = 0; p < RD_PORTS; p++) begin
                hit[p] = granted[p] && (rd_reg[p][BANK_W-1:0] == BANK_W'(b));
            end
        end
        AST_BANK_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= BANK_RD); // R7
    end
endmodule

bind banked_regfile brf_checker u_chk (.*);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    import brf_pkg::*;

    logic                              clk = 1'b0;
    logic                              rst_n = 1'b0;
    logic [BANKS-1:0]                  wr_en = '0;
    logic [BANKS-1:0][ROW_W-1:0]       wr_row = '0;
    logic [BANKS-1:0][BYTES-1:0]       wr_be = '0;
    logic [BANKS-1:0][DATA_W-1:0]      wr_data = '0;
    logic [RD_PORTS-1:0]               rd_valid = '0;
    logic [RD_PORTS-1:0][REG_W-1:0]    rd_reg = '0;
    logic [RD_PORTS-1:0]               rd_stall;
    logic [RD_PORTS-1:0]               rd_rvalid;
    logic [RD_PORTS-1:0][DATA_W-1:0]   rd_data;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic [DATA_W-1:0] model [ROWS*BANKS];

    always #4 clk = ~clk;

    banked_regfile u_dut (.*);

    // Stimulus rows: {register, byte mask, data}
    localparam int NV = 10;
    localparam logic [REG_W+BYTES+DATA_W-1:0] VEC [NV] = '{
        {7'd5,   8'hFF, 64'h0123_4567_89AB_CDEF},
        {7'd5,   8'h0F, 64'hFFFF_FFFF_0000_0000},
        {7'd6,   8'hFF, 64'hDEAD_BEEF_CAFE_F00D},
        {7'd6,   8'h81, 64'h1111_2222_3333_4444},
        {7'd7,   8'h3C, 64'hA5A5_A5A5_A5A5_A5A5},
        {7'd127, 8'hFF, 64'hFEDC_BA98_7654_3210},
        {7'd127, 8'h00, 64'h0000_0000_0000_0000},
        {7'd1,   8'h55, 64'h7777_7777_7777_7777},
        {7'd4,   8'hAA, 64'h9999_8888_6666_5555},
        {7'd126, 8'hF0, 64'h0F0F_0F0F_0F0F_0F0F}
    };

    task automatic chk(input string tag, input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old,
                                                 input logic [BYTES-1:0] be,
                                                 input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r = old;
        for (int i = 0; i < BYTES; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
        return r;
    endfunction

    task automatic drive_wr(input int r, input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d);
        wr_en[r % BANKS]   = 1'b1;
        wr_row[r % BANKS]  = ROW_W'(r / BANKS);
        wr_be[r % BANKS]   = be;
        wr_data[r % BANKS] = d;
    endtask

    task automatic commit(input int r, input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d);
        if (r != 0) model[r] = merge(model[r], be, d);
    endtask

    task automatic do_wr(input int r, input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d);
        @(negedge clk);
        drive_wr(r, be, d);
        @(negedge clk);
        wr_en = '0;
        commit(r, be, d);
    endtask

    // Four-way read; vm = requests, exp_st = expected stall pattern.
    task automatic do_rd(input string tag, input logic [RD_PORTS-1:0] vm,
                         input int r0, input int r1, input int r2, input int r3,
                         input logic [RD_PORTS-1:0] exp_st);
        int rr [RD_PORTS];
        rr[0] = r0; rr[1] = r1; rr[2] = r2; rr[3] = r3;
        @(negedge clk);
        rd_valid = vm;
        for (int p = 0; p < RD_PORTS; p++) rd_reg[p] = REG_W'(rr[p]);
        #1;
        chk({tag, " stall"}, DATA_W'(rd_stall), DATA_W'(exp_st));
        @(negedge clk);
        rd_valid = '0;
        chk({tag, " rvalid"}, DATA_W'(rd_rvalid), DATA_W'(vm & ~exp_st));
        for (int p = 0; p < RD_PORTS; p++) begin
            if (vm[p] && !exp_st[p]) chk($sformatf("%s data p%0d", tag, p), rd_data[p], model[rr[p]]);
        end
    endtask

    initial begin
        for (int i = 0; i < ROWS*BANKS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: reset state
        @(negedge clk);
        chk("R8 idle rvalid", DATA_W'(rd_rvalid), '0);
        do_rd("R8 cleared regs", 4'b1111, 6, 127, 9, 64, 4'b0000);

        // R1 R2: table of byte-masked writes, each read back via another port
        for (int v = 0; v < NV; v++) begin
            do_wr(int'(VEC[v][REG_W+BYTES+DATA_W-1 -: REG_W]),
                  VEC[v][DATA_W+BYTES-1 -: BYTES], VEC[v][DATA_W-1:0]);
            do_rd($sformatf("R1 R2 vec%0d", v), 4'b0100, 0,
                  0, int'(VEC[v][REG_W+BYTES+DATA_W-1 -: REG_W]), 0, 4'b0000);
        end

        // R6: all four requesters on four different banks
        do_wr(12, 8'hFF, 64'h0C0C_0C0C_0C0C_0C0C);
        do_wr(2,  8'hFF, 64'h0202_0202_0202_0202);
        do_rd("R6 spread", 4'b1111, 7, 12, 5, 2, 4'b0000);

        // R7: all four on bank 2, upper two stall
        do_wr(10, 8'hFF, 64'h1010_1010_1010_1010);
        do_wr(14, 8'hFF, 64'h1414_1414_1414_1414);
        do_rd("R7 four on one bank", 4'b1111, 2, 6, 10, 14, 4'b1100);
        // R7: three on bank 1, one on bank 3
        do_wr(9, 8'hFF, 64'h0909_0909_0909_0909);
        do_rd("R7 three on one bank", 4'b1111, 1, 5, 3, 9, 4'b1000);

        // R5: register-0 reads take no slot
        do_wr(8, 8'hFF, 64'h0808_0808_0808_0808);
        do_rd("R5 zero reads no slot", 4'b1111, 0, 0, 4, 8, 4'b0000);
        do_wr(0, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF);
        do_rd("R5 zero after write", 4'b0011, 0, 0, 0, 0, 4'b0000);

        // R9: no stall without request (bank 2 overloaded but masked off)
        do_rd("R9 masked", 4'b0011, 2, 6, 10, 14, 4'b0000);

        // R4: same-edge read and write of register 13
        do_wr(13, 8'hFF, 64'h1313_0000_1313_0000);
        @(negedge clk);
        drive_wr(13, 8'hFF, 64'hABCD_ABCD_ABCD_ABCD);
        rd_valid = 4'b0010;
        rd_reg[1] = REG_W'(13);
        @(negedge clk);
        wr_en = '0;
        rd_valid = '0;
        chk("R4 old value on collision", rd_data[1], 64'h1313_0000_1313_0000);
        commit(13, 8'hFF, 64'hABCD_ABCD_ABCD_ABCD);
        do_rd("R4 new value after", 4'b0010, 0, 13, 0, 0, 4'b0000);

        // R3: no request, no rvalid
        @(negedge clk);
        chk("R3 idle rvalid", DATA_W'(rd_rvalid), '0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule